// File: doc/BRIEF.md
# Race-Safe Interrupt Status Register

This block gathers single-cycle event pulses from hardware sources, for example a start-of-frame event and a frame-done event from a display engine. It latches each pulse into a sticky status bit. It drives one registered interrupt line whenever a latched bit meets its enable bit. Software reaches the block through a small register bus made of a read strobe, a write strobe, a word address and a data word. The status register sits at address 0 and the enable register at address 1. All other addresses read as zero.

The parameter `CLR_ON_READ` picks how software acknowledges events. With clear-on-read, a read strobe to the status address removes exactly the bits returned by that read. With write-one-to-clear, each 1 written to the status address removes that bit alone. In both modes a pulse arriving in the same cycle as the acknowledge lands in the next status value, so no event is lost to a read or write that happens to coincide with it.

Top module: `irq_status_unit`

## Requirements
- R1: A high level on event input bit i during a clock cycle makes status bit i read as 1 from the following cycle on.
- R2: A status bit stays set until it is acknowledged; idle cycles and enable writes do not change it.
- R3: `irqOut` is 1 exactly one cycle after a cycle in which some status bit and its enable bit (address 1) are both 1, and is 0 otherwise.
- R4: The enable register gates only `irqOut`; an event on a disabled source still sets its status bit.
- R5: Clear-on-read mode: a read strobe at address 0 returns the status on `rdData` in that cycle, and those bits read as 0 from the next cycle.
- R6: Clear-on-read mode: an event arriving in the same cycle as a clearing read is set in the next status value, including an event on a bit that the read is returning.
- R7: Clear-on-read mode: a write strobe at address 0 leaves the status unchanged.
- R8: Write-one-to-clear mode: writing at address 0 clears exactly the bits written as 1; a read strobe at address 0 clears nothing.
- R9: Write-one-to-clear mode: an event on a bit in the same cycle as a write-one clearing that bit leaves the bit set.
- R10: Address 1 holds the enable register: a write stores `wrData`, and `rdData` shows it while address 1 is presented.
- R11: Reset (active-low, asynchronous) clears every status and enable bit and drives `irqOut` to 0.
- R12: A read or write at an address other than 0 or 1 returns zero and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evtIn | input | NUM_SRC | One event pulse line per source |
| rdEn | input | 1 | Read strobe |
| wrEn | input | 1 | Write strobe |
| addr | input | ADDR_W | Word address: 0 status, 1 enable |
| wrData | input | NUM_SRC | Write data |
| rdData | output | NUM_SRC | Read data for the addressed register, combinational |
| irqOut | output | 1 | Registered interrupt request |

## Verification
The hardest situation to reach is an event pulse that lands in the very cycle an acknowledge commits. Two cases matter: an event on a bit other than the one being read, and an event on the bit the read is returning. The stimulus sets up a known status value through earlier events. It then drives the event line and the read strobe from the same negative edge, and afterwards reads the status at address 0 without the strobe so that the read clears nothing. A second instance in write-one-to-clear mode repeats this with an event and a clearing write on the same bit.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;
  // Strobes from the bus decoder to the register datapath
  typedef struct packed {
    logic rdStatus;   // clearing read of the status word
    logic wrClear;    // write-one-to-clear of the status word
    logic wrEnable;   // load of the enable word
  } regStrb_t;
endpackage

// File: rtl/irq_stat_ctrl.sv
module irq_stat_ctrl
  import irq_stat_pkg::*;
#(
  parameter int ADDR_W      = 2,
  parameter bit CLR_ON_READ = 1'b1
) (
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output regStrb_t          strb,
  output logic              selStatus,
  output logic              selEnable
);
  localparam logic [ADDR_W-1:0] STATUS_ADDR = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ENABLE_ADDR = ADDR_W'(1);

  always_comb begin
    selStatus = (addr == STATUS_ADDR);
    selEnable = (addr == ENABLE_ADDR);
  end

  // Mode picks which bus strobe acknowledges status bits
  generate
    if (CLR_ON_READ) begin : g_cor
      always_comb begin
        strb.rdStatus = rdEn & selStatus;
        strb.wrClear  = 1'b0;       // R7 status writes ignored
        strb.wrEnable = wrEn & selEnable;
      end
    end else begin : g_w1c
      always_comb begin
        strb.rdStatus = 1'b0;       // R8 reads do not clear
        strb.wrClear  = wrEn & selStatus;
        strb.wrEnable = wrEn & selEnable;
      end
    end
  endgenerate
endmodule

// File: rtl/irq_stat_dpath.sv
module irq_stat_dpath
  import irq_stat_pkg::*;
#(
  parameter int NUM_SRC     = 8,
  parameter bit CLR_ON_READ = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] evtIn,
  input  regStrb_t           strb,
  input  logic               selStatus,
  input  logic               selEnable,
  input  logic [NUM_SRC-1:0] wrData,
  output logic [NUM_SRC-1:0] rdData,
  output logic               irqOut
);
  logic [NUM_SRC-1:0] status;
  logic [NUM_SRC-1:0] enable;
  logic [NUM_SRC-1:0] clrMask;
  logic [NUM_SRC-1:0] statusNext;
  logic               irqQ;

  // Only bits actually acknowledged are removed; new events always OR in
  always_comb begin
    clrMask    = ({NUM_SRC{strb.rdStatus}} & status) |
                 ({NUM_SRC{strb.wrClear}}  & wrData);
    statusNext = (status & ~clrMask) | evtIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      status <= '0;
      enable <= '0;
      irqQ   <= 1'b0;
    end else begin
      status <= statusNext;
      if (strb.wrEnable) enable <= wrData;
      irqQ <= |(status & enable);
    end
  end

  always_comb begin
    rdData = '0;
    if (selStatus)      rdData = status;
    else if (selEnable) rdData = enable;
  end

  assign irqOut = irqQ;

  AST_EVT_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    (|evtIn) |=> ((status & $past(evtIn)) == $past(evtIn))); // R6
  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    (|(status & enable)) |=> irqOut); // R3
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !(|(status & enable)) |=> !irqOut); // R3
  AST_ENABLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrEnable |=> $stable(enable)); // R10

  generate
    if (CLR_ON_READ) begin : g_cor_chk
      AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
        strb.rdStatus |=> ((status & $past(status & ~evtIn)) == '0)); // R5
      AST_NO_WRITE_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
        !strb.rdStatus |=> ((status & $past(status)) == $past(status))); // R7
    end else begin : g_w1c_chk
      AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
        strb.wrClear |=> ((status & $past(wrData & ~evtIn)) == '0)); // R8
      AST_W1C_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
        1'b1 |=> ((status & $past(status & ~(wrData & {NUM_SRC{strb.wrClear}})))
                  == $past(status & ~(wrData & {NUM_SRC{strb.wrClear}})))); // R9
    end
  endgenerate
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import irq_stat_pkg::*;
#(
  parameter int NUM_SRC     = 8,
  parameter int ADDR_W      = 2,
  parameter bit CLR_ON_READ = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] evtIn,
  input  logic               rdEn,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [NUM_SRC-1:0] wrData,
  output logic [NUM_SRC-1:0] rdData,
  output logic               irqOut
);
  regStrb_t strb;
  logic     selStatus;
  logic     selEnable;

  irq_stat_ctrl #(.ADDR_W(ADDR_W), .CLR_ON_READ(CLR_ON_READ)) uCtrl (
    .rdEn(rdEn), .wrEn(wrEn), .addr(addr),
    .strb(strb), .selStatus(selStatus), .selEnable(selEnable)
  );

  irq_stat_dpath #(.NUM_SRC(NUM_SRC), .CLR_ON_READ(CLR_ON_READ)) uDpath (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .strb(strb),
    .selStatus(selStatus), .selEnable(selEnable), .wrData(wrData),
    .rdData(rdData), .irqOut(irqOut)
  );
endmodule

// File: tb/tb_irq_status_unit.sv
module tb_irq_status_unit;
  typedef struct packed {
    logic [7:0] evt;
    logic       rd;
    logic       wr;
    logic [1:0] addr;
    logic [7:0] wd;
    logic [7:0] expRd;
    logic       expIrq;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{8'h00,1'b0,1'b0,2'd0,8'h00,8'h00,1'b0}, // R11 idle after reset
    '{8'h01,1'b0,1'b0,2'd0,8'h00,8'h00,1'b0}, // R1 pulse source 0
    '{8'h00,1'b0,1'b0,2'd0,8'h00,8'h01,1'b0}, // R4 set while disabled
    '{8'h00,1'b0,1'b1,2'd1,8'h01,8'h00,1'b0}, // R10 write enable
    '{8'h00,1'b0,1'b0,2'd1,8'h00,8'h01,1'b0}, // R10 read enable back
    '{8'h00,1'b0,1'b0,2'd0,8'h00,8'h01,1'b1}, // R3 irq one cycle later
    '{8'h02,1'b1,1'b0,2'd0,8'h00,8'h01,1'b1}, // R6 event during read
    '{8'h00,1'b0,1'b0,2'd0,8'h00,8'h02,1'b1}, // R5 R6 read cleared bit0
    '{8'h00,1'b0,1'b0,2'd0,8'h00,8'h02,1'b0}, // R3 irq drops
    '{8'h00,1'b0,1'b1,2'd0,8'hFF,8'h02,1'b0}, // R7 write to status
    '{8'h00,1'b0,1'b0,2'd0,8'h00,8'h02,1'b0}, // R7 R2 unchanged
    '{8'h00,1'b1,1'b0,2'd0,8'h00,8'h02,1'b0}, // R5 clearing read
    '{8'h00,1'b0,1'b0,2'd0,8'h00,8'h00,1'b0}, // R5 cleared
    '{8'h81,1'b0,1'b0,2'd0,8'h00,8'h00,1'b0}, // R1 two sources
    '{8'h00,1'b1,1'b1,2'd2,8'hFF,8'h00,1'b0}, // R12 unmapped access
    '{8'h00,1'b0,1'b0,2'd0,8'h00,8'h81,1'b1}, // R12 no effect
    '{8'h80,1'b1,1'b0,2'd0,8'h00,8'h81,1'b1}, // R6 event on bit being read
    '{8'h00,1'b0,1'b0,2'd0,8'h00,8'h80,1'b1}, // R6 bit7 survives
    '{8'h00,1'b0,1'b0,2'd0,8'h00,8'h80,1'b0}  // R3 disabled bit no irq
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] evtIn = '0, wrData = '0, rdData;
  logic       rdEn = 1'b0, wrEn = 1'b0, irqOut;
  logic [1:0] addr = '0;
  logic [7:0] wEvt = '0, wData = '0, wRdData;
  logic       wRd = 1'b0, wWr = 1'b0, wIrq;
  logic [1:0] wAddr = '0;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_status_unit #(.NUM_SRC(8), .ADDR_W(2), .CLR_ON_READ(1'b1)) dut (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .rdEn(rdEn), .wrEn(wrEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .irqOut(irqOut));

  irq_status_unit #(.NUM_SRC(8), .ADDR_W(2), .CLR_ON_READ(1'b0)) dutW1c (
    .clk(clk), .rstN(rstN), .evtIn(wEvt), .rdEn(wRd), .wrEn(wWr),
    .addr(wAddr), .wrData(wData), .rdData(wRdData), .irqOut(wIrq));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive at the falling edge, sample 1 ns before the next rising edge
  task automatic stepW(input logic [7:0] e, input logic r, input logic w,
                       input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wEvt = e; wRd = r; wWr = w; wAddr = a; wData = d;
    #3;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #3;
    check("R11 reset status", rdData, 8'h00);
    check("R11 reset irq", irqOut, 1'b0);
    @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      evtIn = VECS[i].evt; rdEn = VECS[i].rd; wrEn = VECS[i].wr;
      addr = VECS[i].addr; wrData = VECS[i].wd;
      #3;
      check($sformatf("vec%0d rdData", i), rdData, VECS[i].expRd);
      check($sformatf("vec%0d irqOut", i), irqOut, VECS[i].expIrq);
    end

    // R11 reset mid-run with status 0x80 and enable 0x01
    @(negedge clk);
    evtIn = '0; rdEn = 0; wrEn = 0; addr = 2'd0;
    rstN = 1'b0;
    #3;
    check("R11 status after reset", rdData, 8'h00);
    check("R11 irq after reset", irqOut, 1'b0);
    @(negedge clk);
    addr = 2'd1;
    #3;
    check("R11 enable after reset", rdData, 8'h00);
    @(negedge clk);
    rstN = 1'b1;

    // Write-one-to-clear instance
    stepW(8'h0F, 0, 0, 2'd0, 8'h00);
    stepW(8'h00, 0, 0, 2'd0, 8'h00);
    check("R1 w1c set", wRdData, 8'h0F);
    stepW(8'h00, 1, 0, 2'd0, 8'h00);
    stepW(8'h00, 0, 0, 2'd0, 8'h00);
    check("R8 read does not clear", wRdData, 8'h0F);
    stepW(8'h00, 0, 1, 2'd0, 8'h05);
    stepW(8'h00, 0, 0, 2'd0, 8'h00);
    check("R8 clear only ones", wRdData, 8'h0A);
    stepW(8'h02, 0, 1, 2'd0, 8'h0A);
    stepW(8'h00, 0, 0, 2'd0, 8'h00);
    check("R9 set wins over clear", wRdData, 8'h02);
    stepW(8'h00, 0, 1, 2'd1, 8'h02);
    stepW(8'h00, 0, 0, 2'd0, 8'h00);
    check("R3 w1c irq pending", wIrq, 1'b0);
    stepW(8'h00, 0, 0, 2'd0, 8'h00);
    check("R3 w1c irq asserted", wIrq, 1'b1);
    stepW(8'h00, 0, 1, 2'd0, 8'h02);
    stepW(8'h00, 0, 0, 2'd0, 8'h00);
    check("R8 w1c cleared", wRdData, 8'h00);
    stepW(8'h00, 0, 0, 2'd0, 8'h00);
    check("R3 w1c irq released", wIrq, 1'b0);
    finishRun();
  end

  initial begin
    repeat (5000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finishRun();
  end
endmodule